// File: doc/BRIEF.md
# Supply Fault Response Controller

This block chooses how a power converter controller reacts when its input supply sags or its output rises too high. Both conditions reach it as flags that comparators elsewhere have already registered. For each fault type, a mode input selects the reaction. The block drives four outputs: the converter enable, a power-good flag, a low-side force that keeps the synchronous rectifier conducting, and a latched-off status. A restart command clears a latched shutdown.

For an undervoltage fault there are three reactions:

- Ride through the fault and keep running.
- Keep running for a programmed number of cycles, then latch off if the fault is still there.
- Shut down at once and come back up automatically when the fault clears.

For an overvoltage fault there are two reactions:

- Shut down and come back up automatically when the fault clears.
- Clamp the output through the low-side switch until the next restart attempt.

Automatic restarts are counted against a programmable limit. When the limit is used up, the block latches off. When the converter runs from an external clock, the overvoltage reaction is always a plain shutdown, whatever mode is selected.

Top module: `supply_fault_ctrl`

## Requirements
- R1: While reset is held, all four outputs are low. The first clock edge after reset with no blocking fault raises `conv_en`.
- R2: With `uv_mode` 2'b00 or 2'b11, an undervoltage sampled while running drops `conv_en` at that edge. `conv_en` returns at the first edge that finds the fault gone.
- R3: With `uv_mode` 2'b01, an undervoltage has no effect: `conv_en` stays high and `latched_off` stays low.
- R4: With `uv_mode` 2'b10, call the first edge that samples the undervoltage edge E. If the flag stays high, `conv_en` stays high through edge E+`uv_delay` and falls with `latched_off` rising at edge E+`uv_delay`+1.
- R5: In delayed mode, if the undervoltage flag drops before the delay expires, the delay count clears. A later undervoltage gets the full delay again.
- R6: `latched_off` holds until an edge samples `restart` high. That edge raises `conv_en`. `restart` in any state clears the retry count.
- R7: Each automatic shutdown uses one retry. With `retry_lim` = N > 0, the shutdown that would be number N+1 latches off instead. With `retry_lim` = 0, retries are unlimited.
- R8: With `ov_mode` 0, an overvoltage drops `conv_en` at the sampling edge. `conv_en` returns when the flag clears.
- R9: `pwr_good` is low in any cycle where `ov_flag` is high. Otherwise `pwr_good` equals `conv_en`.
- R10: With `ov_mode` 1 and `ext_clk` low, an overvoltage drops `conv_en` and raises `ls_force`. `ls_force` holds until the edge where the flag is found clear, which restarts the converter.
- R11: With `ext_clk` high, an overvoltage never raises `ls_force`. An active clamp turns into a plain shutdown.
- R12: Overvoltage takes priority over a simultaneous undervoltage. `ls_force` and `conv_en` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uv_flag | input | 1 | Registered input undervoltage flag |
| ov_flag | input | 1 | Registered output overvoltage flag |
| uv_mode | input | 2 | 00/11 shut and retry, 01 ride through, 10 delayed latch |
| ov_mode | input | 1 | 0 shut and retry, 1 low-side clamp |
| uv_delay | input | DLY_W | Cycles of ride-through in delayed mode |
| retry_lim | input | RTY_W | Automatic restart limit, 0 = unlimited |
| ext_clk | input | 1 | Converter runs from an external clock |
| restart | input | 1 | Restart command, clears latch and retry count |
| conv_en | output | 1 | Converter enable |
| pwr_good | output | 1 | Power-good |
| ls_force | output | 1 | Hold the low-side switch on |
| latched_off | output | 1 | Shut down until restart |

## Verification
The bench targets the delay expiry edge. A counter that is off by one would latch a cycle early or late. A delay count that survives a dropped flag would latch too soon on the next undervoltage. It walks the retry limit through zero and small values. An off-by-one there would allow one restart too many or too few, and a design treating zero as "no retries" would latch at once. It also raises both faults together and toggles `ext_clk` during a clamp. Wrong priority or a missing override would show `ls_force` high beside an external clock, or `conv_en` staying up under overvoltage.

// File: rtl/supply_fault_ctrl.sv
module supply_fault_ctrl #(
  parameter int DLY_W = 16,
  parameter int RTY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             uv_flag,
  input  logic             ov_flag,
  input  logic [1:0]       uv_mode,
  input  logic             ov_mode,
  input  logic [DLY_W-1:0] uv_delay,
  input  logic [RTY_W-1:0] retry_lim,
  input  logic             ext_clk,
  input  logic             restart,
  output logic             conv_en,
  output logic             pwr_good,
  output logic             ls_force,
  output logic             latched_off
);
  localparam logic [1:0]       UV_RIDE = 2'b01;
  localparam logic [1:0]       UV_DLY  = 2'b10;
  localparam logic [RTY_W-1:0] R_MAX   = {RTY_W{1'b1}};

  typedef enum logic [2:0] {S_RUN, S_UVW, S_SHUT, S_CLAMP, S_LATCH} st_t;

  st_t              st, st_n;
  logic [DLY_W-1:0] dcnt, dcnt_n;
  logic [RTY_W-1:0] rcnt, rcnt_n;

  logic blocking, out_of_retries, clamp_ok;
  assign blocking       = ov_flag | (uv_flag & (uv_mode != UV_RIDE));
  assign out_of_retries = (retry_lim != '0) && (rcnt >= retry_lim);
  assign clamp_ok       = ov_mode & ~ext_clk;

  always_comb begin
    st_n   = st;
    dcnt_n = '0;
    rcnt_n = rcnt;
    unique case (st)
      S_RUN, S_UVW: begin
        if (ov_flag) begin
          if (out_of_retries) st_n = S_LATCH;
          else begin
            st_n   = clamp_ok ? S_CLAMP : S_SHUT;
            rcnt_n = (rcnt == R_MAX) ? rcnt : rcnt + 1'b1;
          end
        end else if (uv_flag && uv_mode == UV_DLY) begin
          if (st == S_RUN) st_n = S_UVW;
          else if (dcnt >= uv_delay) st_n = S_LATCH;
          else begin
            st_n   = S_UVW;
            dcnt_n = dcnt + 1'b1;
          end
        end else if (uv_flag && uv_mode != UV_RIDE) begin
          if (out_of_retries) st_n = S_LATCH;
          else begin
            st_n   = S_SHUT;
            rcnt_n = (rcnt == R_MAX) ? rcnt : rcnt + 1'b1;
          end
        end else begin
          st_n = S_RUN;
        end
      end
      S_SHUT:  if (!blocking) st_n = S_RUN;
      S_CLAMP: begin
        if (!blocking) st_n = S_RUN;
        else if (ext_clk) st_n = S_SHUT;
      end
      S_LATCH: if (restart) st_n = S_RUN;
      default: st_n = S_SHUT;
    endcase
    if (restart) rcnt_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_SHUT;
      dcnt <= '0;
      rcnt <= '0;
    end else begin
      st   <= st_n;
      dcnt <= dcnt_n;
      rcnt <= rcnt_n;
    end
  end

  assign conv_en     = rst_n && (st == S_RUN || st == S_UVW);
  assign pwr_good    = conv_en & ~ov_flag;
  assign ls_force    = rst_n && (st == S_CLAMP);
  assign latched_off = rst_n && (st == S_LATCH);
endmodule

module supply_fault_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       uv_flag,
  input logic       ov_flag,
  input logic [1:0] uv_mode,
  input logic       ext_clk,
  input logic       restart,
  input logic       conv_en,
  input logic       ls_force,
  input logic       latched_off
);
  AST_OV_SHUTS: assert property (@(posedge clk) disable iff (!rst_n)
    ov_flag && conv_en |=> !conv_en); // R8
  AST_UV_RIDE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_en && uv_flag && !ov_flag && uv_mode == 2'b01 |=> conv_en); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off && !restart |=> latched_off); // R6
  AST_RESTART_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    latched_off && restart |=> conv_en); // R6
  AST_EXT_NO_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ext_clk && (ov_flag || ls_force) |=> !ls_force); // R11
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ls_force && conv_en)); // R12
endmodule

bind supply_fault_ctrl supply_fault_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .ov_flag(ov_flag),
  .uv_mode(uv_mode), .ext_clk(ext_clk), .restart(restart),
  .conv_en(conv_en), .ls_force(ls_force), .latched_off(latched_off)
);

// File: tb/tb_supply_fault_ctrl.sv
module tb_supply_fault_ctrl;
  localparam int DLY_W = 16;
  localparam int RTY_W = 4;

  logic clk = 0, rst_n = 0;
  logic uv_flag = 0, ov_flag = 0, ov_mode = 0, ext_clk = 0, restart = 0;
  logic [1:0] uv_mode = 2'b00;
  logic [DLY_W-1:0] uv_delay = '0;
  logic [RTY_W-1:0] retry_lim = '0;
  logic conv_en, pwr_good, ls_force, latched_off;

  always #5 clk = ~clk;

  supply_fault_ctrl #(.DLY_W(DLY_W), .RTY_W(RTY_W)) dut (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .ov_flag(ov_flag),
    .uv_mode(uv_mode), .ov_mode(ov_mode), .uv_delay(uv_delay),
    .retry_lim(retry_lim), .ext_clk(ext_clk), .restart(restart),
    .conv_en(conv_en), .pwr_good(pwr_good), .ls_force(ls_force),
    .latched_off(latched_off));

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model: 0 run, 1 uv wait, 2 shut, 3 clamp, 4 latched
  int m_st = 2, m_d = 0, m_r = 0;

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit f_en(int s);  return s == 0 || s == 1; endfunction

  task automatic model_step();
    int ns, nd, nr;
    bit blk, oor;
    ns = m_st; nd = 0; nr = m_r;
    blk = ov_flag || (uv_flag && uv_mode != 2'b01);
    oor = (retry_lim != 0) && (m_r >= retry_lim);
    case (m_st)
      0, 1: begin
        if (ov_flag) begin
          if (oor) ns = 4;
          else begin ns = (ov_mode && !ext_clk) ? 3 : 2; nr = (m_r == 15) ? 15 : m_r + 1; end
        end else if (uv_flag && uv_mode == 2'b10) begin
          if (m_st == 0) ns = 1;
          else if (m_d >= uv_delay) ns = 4;
          else begin ns = 1; nd = m_d + 1; end
        end else if (uv_flag && uv_mode != 2'b01) begin
          if (oor) ns = 4;
          else begin ns = 2; nr = (m_r == 15) ? 15 : m_r + 1; end
        end else ns = 0;
      end
      2: if (!blk) ns = 0;
      3: begin if (!blk) ns = 0; else if (ext_clk) ns = 2; end
      default: if (restart) ns = 0;
    endcase
    if (restart) nr = 0;
    m_st = ns; m_d = nd; m_r = nr;
  endtask

  // one clock: inputs already set at negedge; compare after edge
  task automatic cyc(string tag);
    model_step();
    @(posedge clk); #1;
    chk(tag, "conv_en", conv_en, f_en(m_st));
    chk(tag, "pwr_good", pwr_good, f_en(m_st) && !ov_flag);
    chk(tag, "ls_force", ls_force, m_st == 3);
    chk(tag, "latched_off", latched_off, m_st == 4);
    chk("R12", "no overlap", ls_force && conv_en, 1'b0);
    @(negedge clk);
  endtask

  task automatic clear_all();
    uv_flag = 0; ov_flag = 0; restart = 1; cyc("R6"); restart = 0; cyc("R6");
  endtask

  initial begin
    #200_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    @(negedge clk); @(negedge clk);
    chk("R1", "conv_en in reset", conv_en, 0);
    chk("R1", "pwr_good in reset", pwr_good, 0);
    chk("R1", "ls_force in reset", ls_force, 0);
    chk("R1", "latched_off in reset", latched_off, 0);
    rst_n = 1;
    cyc("R1");
    chk("R1", "enable after reset", conv_en, 1);

    // R2 immediate shutdown / auto re-enable, both encodings
    for (int m = 0; m < 2; m++) begin
      uv_mode = (m == 0) ? 2'b00 : 2'b11;
      uv_flag = 1; cyc("R2");
      chk("R2", "uv shuts", conv_en, 0);
      cyc("R2"); uv_flag = 0; cyc("R2");
      chk("R2", "uv clear re-enables", conv_en, 1);
    end
    clear_all();

    // R3 ride through
    uv_mode = 2'b01; uv_flag = 1;
    for (int i = 0; i < 6; i++) cyc("R3");
    chk("R3", "ride keeps enable", conv_en, 1);
    chk("R3", "ride no latch", latched_off, 0);
    uv_flag = 0; cyc("R3");

    // R4 delayed latch timing, delay 3
    uv_mode = 2'b10; uv_delay = 3; uv_flag = 1;
    for (int i = 0; i < 4; i++) begin
      cyc("R4");
      chk("R4", "enabled during delay", conv_en, 1);
    end
    cyc("R4");
    chk("R4", "latched after delay", latched_off, 1);
    chk("R4", "off after delay", conv_en, 0);
    uv_flag = 0;
    for (int i = 0; i < 3; i++) cyc("R6");
    chk("R6", "latch holds", latched_off, 1);
    restart = 1; cyc("R6"); restart = 0;
    chk("R6", "restart runs", conv_en, 1);

    // R5 delay count cleared by dropped flag
    uv_flag = 1; cyc("R5"); cyc("R5"); cyc("R5");
    uv_flag = 0; cyc("R5");
    uv_flag = 1;
    for (int i = 0; i < 4; i++) cyc("R5");
    chk("R5", "full delay again", conv_en, 1);
    cyc("R5");
    chk("R5", "latched after full delay", latched_off, 1);
    clear_all();

    // R7 retry limit 2, then unlimited
    uv_mode = 2'b00; retry_lim = 2;
    for (int k = 0; k < 3; k++) begin
      uv_flag = 1; cyc("R7"); uv_flag = 0; cyc("R7");
    end
    chk("R7", "latched after limit", latched_off, 1);
    clear_all();
    retry_lim = 0;
    for (int k = 0; k < 20; k++) begin
      uv_flag = 1; cyc("R7"); uv_flag = 0; cyc("R7");
    end
    chk("R7", "unlimited retries", conv_en, 1);

    // R8 / R9 overvoltage shutdown
    ov_mode = 0; ov_flag = 1; #1;
    chk("R9", "pg drops at once", pwr_good, 0);
    cyc("R8");
    chk("R8", "ov shuts", conv_en, 0);
    ov_flag = 0; cyc("R8");
    chk("R8", "ov clear re-enables", conv_en, 1);
    chk("R9", "pg follows enable", pwr_good, 1);

    // R10 clamp, R12 priority
    ov_mode = 1; ov_flag = 1; uv_mode = 2'b10; uv_flag = 1; cyc("R12");
    chk("R12", "ov wins over uv", ls_force, 1);
    cyc("R10");
    chk("R10", "clamp holds", ls_force, 1);
    ov_flag = 0; uv_flag = 0; cyc("R10");
    chk("R10", "clamp ends on restart", ls_force, 0);
    chk("R10", "restart after clamp", conv_en, 1);

    // R11 ext clock forces shutdown and breaks clamp
    ext_clk = 1; ov_flag = 1; cyc("R11");
    chk("R11", "no clamp with ext clk", ls_force, 0);
    ov_flag = 0; cyc("R11");
    ext_clk = 0; ov_flag = 1; cyc("R11");
    chk("R11", "clamp without ext clk", ls_force, 1);
    ext_clk = 1; cyc("R11");
    chk("R11", "clamp released by ext clk", ls_force, 0);
    ov_flag = 0; ext_clk = 0; clear_all();

    // constrained random against the model
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) uv_flag = ~uv_flag;
      if ($urandom_range(11) == 0) ov_flag = ~ov_flag;
      if ($urandom_range(49) == 0) uv_mode = 2'($urandom_range(3));
      if ($urandom_range(49) == 0) ov_mode = 1'($urandom_range(1));
      if ($urandom_range(79) == 0) ext_clk = ~ext_clk;
      if ($urandom_range(99) == 0) uv_delay = DLY_W'($urandom_range(5));
      if ($urandom_range(99) == 0) retry_lim = RTY_W'($urandom_range(3));
      restart = ($urandom_range(29) == 0);
      cyc("R12");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule